// File: doc/BRIEF.md
# Indirectly Selected Potentiometer Register Bank

This block holds the registers of a four-channel digitally controlled potentiometer. A host reaches it through a small byte-level port. A start strobe opens a transaction and latches a byte address. Write strobes carry data bytes, and read strobes return a byte one clock later. Each channel has one volatile wiper register and four data registers. The current wiper values drive the `wiper_o` outputs, one byte per channel.

A three-bit selector in a status register decides which page the channel addresses 0 to 3 reach. The pages are the wiper page and four data-register pages. Any access to a data register, whether a read or a write, also loads that byte into the same channel's wiper. A host can therefore recall a stored setting onto a wiper with a single read.

A transaction runs through the states IDLE, OPEN and SPENT. IDLE holds until the first start. Any start moves the machine to OPEN, which is the transition *open*. An access that uses the last byte of the burst moves OPEN to SPENT, which is the transition *exhaust*. In SPENT every strobe is ignored until the next start reopens the transaction.

Top module: `dpot_regbank`

## Requirements
- R1: After reset every wiper output, every data register, the selector and `rd_data_o` are 00h.
- R2: Address 07h reaches the selector. A write stores only bits 2:0, where bit 0 is the nonvolatile-select flag and bits 2:1 are the data-register index. A read returns the stored bits with bits 7:3 reading as zero.
- R3: While selector bit 0 is 0, addresses 0 to 3 reach the wiper register of channel 0 to 3, whatever bits 2:1 hold.
- R4: While selector bit 0 is 1, addresses 0 to 3 reach data register n of the channel, where n is selector bits 2:1. A write there also loads the byte into that channel's wiper on the same edge.
- R5: A read of a data register loads its value into that channel's wiper on the same edge that makes the read data valid.
- R6: Read data is registered. It is valid one clock after an accepted read strobe and holds its value until the next accepted read.
- R7: Within one transaction, each accepted access advances the channel index by one, wrapping from 3 to 0.
- R8: A transaction accepts at most four accesses. Strobes before the first start, after the fourth access, or in the same cycle as a start are ignored. If write and read are both strobed, only the write takes effect.
- R9: At addresses 04h to 06h, writes change nothing and reads return 00h.
- R10: An address with any of bits 7:3 set, other than 07h, reaches nothing. Writes change nothing and reads return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start_i | input | 1 | Opens a transaction and latches `addr_i` |
| addr_i | input | 8 | Byte address of the transaction |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write byte |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read byte |
| wiper_o | output | 32 | Wiper values; channel c sits in bits 8c+7:8c |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit data, four data registers per channel and a burst of four. With these values, every page-select combination can be reached within a few dozen random transactions. The same holds for every wrap from channel 3 to channel 0 and for every over-length burst. Random address bytes also land on the unused and out-of-range addresses. Directed cases add the reserved status bits, a read that recalls a stored setting, and strobes sent outside any open transaction.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_OPEN,
        XS_SPENT
    } xfer_state_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_STAT,
        TGT_WIPER,
        TGT_DATA
    } tgt_e;

endpackage

// File: rtl/dpot_xfer_fsm.sv
module dpot_xfer_fsm
    import dpot_pkg::*;
#(
    parameter int AW        = 8,
    parameter int CW        = 2,
    parameter int MAX_BURST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    output logic          acc_o,
    output logic [AW-1:0] base_o,
    output logic [CW-1:0] ptr_o,
    output xfer_state_e   state_o
);

    localparam int CNTW = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;

    xfer_state_e   state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [CW-1:0]   ptr_q;
    logic [AW-1:0]   base_q;
    logic            last_beat;

    assign last_beat = (cnt_q == CNTW'(MAX_BURST - 1));

    // state register and transaction bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            cnt_q   <= '0;
            ptr_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                base_q <= addr_i;
                ptr_q  <= addr_i[CW-1:0];
                cnt_q  <= '0;
            end else if (acc_o) begin
                ptr_q <= ptr_q + 1'b1;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  if (start_i) state_d = XS_OPEN;
            XS_OPEN: begin
                if (start_i)                state_d = XS_OPEN;
                else if (acc_o && last_beat) state_d = XS_SPENT;
            end
            XS_SPENT: if (start_i) state_d = XS_OPEN;
            default:  state_d = XS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_o = 1'b0;
        unique case (state_q)
            XS_OPEN:  acc_o = !start_i && (wr_i || rd_i);
            XS_IDLE,
            XS_SPENT: acc_o = 1'b0;
            default:  acc_o = 1'b0;
        endcase
    end

    assign base_o  = base_q;
    assign ptr_o   = ptr_q;
    assign state_o = state_q;

endmodule

// File: rtl/dpot_tgt_decode.sv
module dpot_tgt_decode
    import dpot_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NCH       = 4,
    parameter int SW        = 2,
    parameter int STAT_ADDR = 7
) (
    input  logic [AW-1:0] base_i,
    input  logic          nv_i,
    input  logic [SW-1:0] sel_i,
    output tgt_e          tgt_o,
    output logic [SW-1:0] idx_o
);

    always_comb begin
        if (base_i == AW'(STAT_ADDR))
            tgt_o = TGT_STAT;
        else if (base_i < AW'(NCH))
            tgt_o = nv_i ? TGT_DATA : TGT_WIPER;
        else
            tgt_o = TGT_NONE;
        idx_o = sel_i;
    end

endmodule

// File: rtl/dpot_reg_array.sv
module dpot_reg_array
    import dpot_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int DRN = 4,
    parameter int CW  = 2,
    parameter int SW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              re_i,
    input  tgt_e              tgt_i,
    input  logic [CW-1:0]     ch_i,
    input  logic [SW-1:0]     idx_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [NCH*DW-1:0] wiper_o,
    output logic [DW-1:0]     rd_wiper_o,
    output logic [DW-1:0]     rd_dr_o
);

    logic [DW-1:0] wip_all [NCH];
    logic [DW-1:0] dr_all  [NCH][DRN];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] wip_q;
        logic [DW-1:0] dr_q [DRN];
        logic          hit;

        assign hit = (ch_i == CW'(c));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wip_q <= '0;
                for (int k = 0; k < DRN; k++) dr_q[k] <= '0;
            end else if (hit) begin
                if (we_i && tgt_i == TGT_WIPER) begin
                    wip_q <= wdata_i;
                end else if (we_i && tgt_i == TGT_DATA) begin
                    dr_q[idx_i] <= wdata_i;
                    wip_q       <= wdata_i;
                end else if (re_i && tgt_i == TGT_DATA) begin
                    wip_q <= dr_q[idx_i];
                end
            end
        end

        assign wip_all[c] = wip_q;
        assign wiper_o[c*DW +: DW] = wip_q;
        for (genvar k = 0; k < DRN; k++) begin : g_dr
            assign dr_all[c][k] = dr_q[k];
        end
    end

    assign rd_wiper_o = wip_all[ch_i];
    assign rd_dr_o    = dr_all[ch_i][idx_i];

endmodule

// File: rtl/dpot_regbank.sv
module dpot_regbank
    import dpot_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int DW        = 8,
    parameter int DRN       = 4,
    parameter int MAX_BURST = 4,
    parameter int AW        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              wr_en_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic              rd_en_i,
    output logic [DW-1:0]     rd_data_o,
    output logic [NCH*DW-1:0] wiper_o
);

    localparam int CW        = $clog2(NCH);
    localparam int SW        = $clog2(DRN);
    localparam int STW       = 1 + SW;
    localparam int STAT_ADDR = 7;

    xfer_state_e   xstate;
    logic          acc;
    logic [AW-1:0] base;
    logic [CW-1:0] ptr;
    tgt_e          tgt;
    logic [SW-1:0] dr_idx;
    logic [STW-1:0] status_q;
    logic          wr_fire, rd_fire;
    logic [DW-1:0] rd_wiper, rd_dr, rd_q;

    dpot_xfer_fsm #(.AW(AW), .CW(CW), .MAX_BURST(MAX_BURST)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (txn_start_i),
        .addr_i  (addr_i),
        .wr_i    (wr_en_i),
        .rd_i    (rd_en_i),
        .acc_o   (acc),
        .base_o  (base),
        .ptr_o   (ptr),
        .state_o (xstate)
    );

    dpot_tgt_decode #(.AW(AW), .NCH(NCH), .SW(SW), .STAT_ADDR(STAT_ADDR)) dec_i (
        .base_i (base),
        .nv_i   (status_q[0]),
        .sel_i  (status_q[STW-1:1]),
        .tgt_o  (tgt),
        .idx_o  (dr_idx)
    );

    assign wr_fire = acc && wr_en_i;
    assign rd_fire = acc && !wr_en_i && rd_en_i;

    dpot_reg_array #(.NCH(NCH), .DW(DW), .DRN(DRN), .CW(CW), .SW(SW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (wr_fire),
        .re_i       (rd_fire),
        .tgt_i      (tgt),
        .ch_i       (ptr),
        .idx_i      (dr_idx),
        .wdata_i    (wr_data_i),
        .wiper_o    (wiper_o),
        .rd_wiper_o (rd_wiper),
        .rd_dr_o    (rd_dr)
    );

    // selector register: only the low STW bits exist
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (wr_fire && tgt == TGT_STAT)
            status_q <= wr_data_i[STW-1:0];
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_fire) begin
            unique case (tgt)
                TGT_STAT:  rd_q <= DW'(status_q);
                TGT_WIPER: rd_q <= rd_wiper;
                TGT_DATA:  rd_q <= rd_dr;
                default:   rd_q <= '0;
            endcase
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/dpot_regbank_chk.sv
module dpot_regbank_chk
    import dpot_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int CW  = 2,
    parameter int STW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              acc,
    input logic              rd_fire,
    input tgt_e              tgt,
    input logic [CW-1:0]     ch,
    input xfer_state_e       state,
    input logic [DW-1:0]     rd_data,
    input logic [NCH*DW-1:0] wiper
);

    // R2
    stat_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && tgt == TGT_STAT) |=> ((rd_data >> STW) == '0));

    // R5
    recall_to_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && tgt == TGT_DATA) |=> (wiper[$past(ch)*DW +: DW] == rd_data));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rd_data));

    // R7
    ch_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (tgt == TGT_WIPER || tgt == TGT_DATA) && ch == CW'(NCH - 1)) |=> (ch == '0));

    // R8
    spent_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_SPENT && !start) |=> (state == XS_SPENT));

    // R8
    idle_wiper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(wiper));

    // R9
    unused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && tgt == TGT_NONE) |=> (rd_data == '0));

endmodule

bind dpot_regbank dpot_regbank_chk #(.NCH(NCH), .DW(DW), .CW(CW), .STW(STW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (txn_start_i),
    .acc     (acc),
    .rd_fire (rd_fire),
    .tgt     (tgt),
    .ch      (ptr),
    .state   (xstate),
    .rd_data (rd_data_o),
    .wiper   (wiper_o)
);

// File: tb/dpot_regbank_tb_top.sv
module dpot_regbank_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rd = 1'b0;
    logic [7:0]  rdata;
    logic [31:0] wipers;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_wip [4];
    logic [7:0] m_dr [4][4];
    logic [2:0] m_stat;
    logic [7:0] m_last;
    bit         m_open;
    int         m_cnt, m_ptr;
    logic [7:0] m_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpot_regbank dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start_i (start),
        .addr_i      (addr),
        .wr_en_i     (wr),
        .wr_data_i   (wdata),
        .rd_en_i     (rd),
        .rd_data_o   (rdata),
        .wiper_o     (wipers)
    );

    // 0 none, 1 selector, 2 wiper, 3 data register
    function automatic int kind_of();
        if (m_base == 8'h07) return 1;
        if (m_base < 8'h04)  return m_stat[0] ? 3 : 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_wipers();
        return {m_wip[3], m_wip[2], m_wip[1], m_wip[0]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_advance();
        m_ptr = (m_ptr + 1) % 4;
        m_cnt++;
        if (m_cnt == 4) m_open = 1'b0;
    endtask

    task automatic do_start(logic [7:0] a);
        @(negedge clk);
        start = 1'b1; addr = a;
        @(negedge clk);
        start = 1'b0;
        m_open = 1'b1; m_cnt = 0; m_ptr = a % 4; m_base = a;
    endtask

    task automatic do_wr(logic [7:0] d, string tag);
        @(negedge clk);
        wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        if (m_open) begin
            case (kind_of())
                1: m_stat = d[2:0];
                2: m_wip[m_ptr] = d;
                3: begin m_dr[m_ptr][m_stat[2:1]] = d; m_wip[m_ptr] = d; end
                default: ;
            endcase
            m_advance();
        end
        chk(tag, wipers, exp_wipers());
    endtask

    task automatic do_rd(string tag);
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        if (m_open) begin
            case (kind_of())
                1: m_last = {5'b0, m_stat};
                2: m_last = m_wip[m_ptr];
                3: begin m_last = m_dr[m_ptr][m_stat[2:1]]; m_wip[m_ptr] = m_last; end
                default: m_last = 8'h00;
            endcase
            m_advance();
        end
        chk(tag, {24'h0, rdata}, {24'h0, m_last});
        chk(tag, wipers, exp_wipers());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd4711);
        for (int c = 0; c < 4; c++) begin
            m_wip[c] = '0;
            for (int k = 0; k < 4; k++) m_dr[c][k] = '0;
        end
        m_stat = '0; m_last = '0; m_open = 1'b0; m_cnt = 0; m_ptr = 0; m_base = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 wipers", wipers, 32'h0);
        chk("R1 rd_data", {24'h0, rdata}, 32'h0);
        // R8 strobes before any start are ignored
        do_wr(8'h5A, "R8 pre-start write");
        do_rd("R8 pre-start read");

        // R2 selector write keeps bits 2:0 only
        do_start(8'h07);
        do_wr(8'hFE, "R2 write");
        do_rd("R2 readback");
        chk("R2 value", {24'h0, rdata}, 32'h06);

        // R3 NV flag clear: wiper page despite index bits = 11
        do_start(8'h00);
        do_wr(8'h11, "R3 ch0");
        do_wr(8'h22, "R3 ch1");
        chk("R3 wiper1", {24'h0, wipers[15:8]}, 32'h22);

        // R4 data register 2 write copies to wiper
        do_start(8'h07);
        do_wr(8'h05, "R4 select dr2");
        do_start(8'h02);
        do_wr(8'hA7, "R4 dr write ch2");
        chk("R4 wiper2", {24'h0, wipers[23:16]}, 32'hA7);

        // R5 overwrite wiper2 then recall from dr2
        do_start(8'h07);
        do_wr(8'h00, "R5 select wiper page");
        do_start(8'h02);
        do_wr(8'h3C, "R5 wiper overwrite");
        do_start(8'h07);
        do_wr(8'h05, "R5 select dr2");
        do_start(8'h02);
        do_rd("R5 recall");
        chk("R5 wiper2 recalled", {24'h0, wipers[23:16]}, 32'hA7);
        // R6 read data holds after non-read activity
        do_wr(8'h99, "R6 write after read");
        chk("R6 hold", {24'h0, rdata}, 32'hA7);

        // R7 page write from channel 2 wraps; R8 fifth byte ignored
        do_start(8'h02);
        do_wr(8'hC2, "R7 ch2");
        do_wr(8'hC3, "R7 ch3");
        do_wr(8'hC0, "R7 wrap ch0");
        do_wr(8'hC1, "R7 ch1");
        do_wr(8'hEE, "R8 fifth byte");
        chk("R7 wrapped wipers", wipers, 32'hC3C2C1C0);

        // R9 unused address
        do_start(8'h05);
        do_wr(8'h77, "R9 write ignored");
        do_rd("R9 read zero");
        chk("R9 zero", {24'h0, rdata}, 32'h0);

        // R10 high address bits set
        do_start(8'h41);
        do_wr(8'h66, "R10 write ignored");
        do_rd("R10 read zero");

        // R8 strobe together with start is ignored
        @(negedge clk);
        start = 1'b1; addr = 8'h01; wr = 1'b1; wdata = 8'h55;
        @(negedge clk);
        start = 1'b0; wr = 1'b0;
        m_open = 1'b1; m_cnt = 0; m_ptr = 1; m_base = 8'h01;
        chk("R8 start-cycle write", wipers, exp_wipers());
        // R8 both strobes: write wins
        @(negedge clk);
        wr = 1'b1; rd = 1'b1; wdata = 8'h4D;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        m_dr[1][m_stat[2:1]] = 8'h4D; m_wip[1] = 8'h4D; m_advance();
        chk("R8 write wins wipers", wipers, exp_wipers());
        chk("R8 write wins rd_data", {24'h0, rdata}, {24'h0, m_last});

        // random mix covering R2 R3 R4 R5 R7 R8 R9 R10
        for (int t = 0; t < 400; t++) begin
            int r;
            logic [7:0] a;
            int nops;
            r = int'($urandom % 12);
            if (r < 8)       a = 8'(r);
            else if (r < 10) a = 8'h07;
            else             a = 8'(((($urandom % 31) + 1) << 3) | ($urandom % 8));
            do_start(a);
            nops = int'($urandom % 6) + 1;
            for (int j = 0; j < nops; j++) begin
                if ($urandom % 2) do_wr(8'($urandom), "R4 R7 R8 random write");
                else              do_rd("R5 R6 R9 R10 random read");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule